// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that always runs on the main clock. It gives a warning before it forces a reset. A two-bit mode code selects one of four interval lengths. When the interval runs out, a sticky interrupt flag is set. A fixed grace window later, a sticky timeout flag is set and, if enabled, a one-cycle reset request is issued. Software keeps the system alive by pulsing a restart strobe before the interval ends. That strobe also captures the mode code, so the interval in force only changes at a restart.

The warning and the reset stages have separate enables. The grace window runs whether or not the interrupt is enabled. The timeout flag survives the reset request it produces, so code running after the reset can find the cause. Register decoding, the CPU and the distribution of the reset are outside the block. A shift parameter shortens every interval by the same power of two for simulation.

Top module: `wdog_two_stage`

## Requirements
- R1: Mode code m (00, 01, 10, 11) selects an interval of 2^(17+3m-SHIFT) clocks, which is 2^17, 2^20, 2^23 or 2^26 when SHIFT is 0. The interrupt flag rises on exactly that many rising edges after the edge that sampled restart, or after reset release.
- R2: The interrupt flag is set when the interval completes. irq_o is high while the interrupt flag and irq_en_i are both high.
- R3: The timeout flag rises exactly GRACE clocks (512 by default) after the interrupt flag rises. This happens whatever irq_en_i is and whether or not the interrupt flag was cleared in between.
- R4: A restart pulse reloads a full interval. A restart during the grace window prevents that timeout. A restart sampled on the same edge as the interval end wins, and no flag is set on that edge.
- R5: Each flag stays high until its clear input is pulsed. If a set and a clear for the same flag happen on one edge, the set wins.
- R6: rst_req_o is a single-cycle pulse. It rises on the same edge as the timeout flag, and only if rst_en_i is high in the cycle the grace window ends.
- R7: The timeout flag is not cleared by the reset request. It is cleared only by to_clr_i or by rst_ni.
- R8: The mode code is captured only at a restart, and a change without a restart has no effect. After reset the captured code is 00.
- R9: The counter has no run or stop control. After a timeout, a new interval starts at once with the captured mode, and the interrupt flag rises again one interval later.
- R10: During and right after reset, irq_flag_o, to_flag_o, irq_o and rst_req_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Interval code, captured at restart |
| irq_en_i | input | 1 | Enables irq_o |
| rst_en_i | input | 1 | Enables rst_req_o |
| restart_i | input | 1 | Restart strobe, one cycle |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| to_clr_i | input | 1 | Clears the timeout flag |
| irq_flag_o | output | 1 | Sticky interrupt (warning) flag |
| to_flag_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Two pairs of events can land on the same edge: the end of an interval and a restart, and the setting of a flag and its clear. The bench places a restart, and in a separate run an interrupt-flag clear, on exactly the edge where the interval ends. It does this by counting edges from a known restart. It then checks that the restart left the flag low and started a full new interval, and that the flag set beat the clear.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_GRACE = 1'b1
  } wdog_stage_e;

  // interval length for a mode code after scaling
  function automatic logic [31:0] wdog_limit(input logic [1:0] code, input int shift);
    return 32'd1 << (17 + 3 * int'(code) - shift);
  endfunction

endpackage

// File: rtl/wdog_interval.sv
module wdog_interval
  import wdog_pkg::*;
#(
  parameter int SHIFT = 0,
  parameter int GRACE = 512,
  parameter int CW    = 27
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [1:0] mode_i,
  output logic       warn_evt_o,
  output logic       expire_evt_o
);

  logic [CW-1:0] lim_tab [4];
  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim_tab[g] = CW'(wdog_limit(2'(g), SHIFT));
  end

  logic [CW-1:0] cnt_q, cnt_d;
  wdog_stage_e   stage_q, stage_d;
  logic [1:0]    mode_q;
  logic          mode_en;
  logic [CW-1:0] end_val;
  logic          at_end;

  always_comb begin
    end_val = (stage_q == ST_GRACE) ? CW'(GRACE) : lim_tab[mode_q];
    at_end  = (cnt_q == end_val - 1'b1);
    mode_en = restart_i;
    cnt_d   = cnt_q + 1'b1;
    stage_d = stage_q;
    if (restart_i) begin
      cnt_d   = '0;
      stage_d = ST_RUN;
    end else if (at_end) begin
      cnt_d   = '0;
      stage_d = (stage_q == ST_RUN) ? ST_GRACE : ST_RUN;
    end
  end

  assign warn_evt_o   = !restart_i && at_end && (stage_q == ST_RUN);
  assign expire_evt_o = !restart_i && at_end && (stage_q == ST_GRACE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      stage_q <= ST_RUN;
    end else begin
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 2'b00;
    end else if (mode_en) begin
      mode_q <= mode_i;
    end
  end

endmodule

// File: rtl/wdog_flag.sv
module wdog_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_d;

  always_comb begin
    flag_d = set_i | (flag_o & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
    end else begin
      flag_o <= flag_d;
    end
  end

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int SHIFT = 0,
  parameter int GRACE = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       irq_en_i,
  input  logic       rst_en_i,
  input  logic       restart_i,
  input  logic       irq_clr_i,
  input  logic       to_clr_i,
  output logic       irq_flag_o,
  output logic       to_flag_o,
  output logic       irq_o,
  output logic       rst_req_o
);

  localparam logic [31:0] LIM_MAX = wdog_limit(2'b11, SHIFT);
  localparam int          SPAN    = (LIM_MAX > 32'(GRACE)) ? int'(LIM_MAX) : GRACE;
  localparam int          CW      = $clog2(SPAN) + 1;

  logic warn_evt;
  logic expire_evt;
  logic rst_req_d;

  wdog_interval #(
    .SHIFT (SHIFT),
    .GRACE (GRACE),
    .CW    (CW)
  ) i_interval (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (restart_i),
    .mode_i       (mode_i),
    .warn_evt_o   (warn_evt),
    .expire_evt_o (expire_evt)
  );

  wdog_flag i_irq_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (warn_evt),
    .clr_i  (irq_clr_i),
    .flag_o (irq_flag_o)
  );

  wdog_flag i_to_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (expire_evt),
    .clr_i  (to_clr_i),
    .flag_o (to_flag_o)
  );

  assign irq_o = irq_flag_o & irq_en_i;

  always_comb begin
    rst_req_d = expire_evt & rst_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= rst_req_d;
    end
  end

endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rst_en_i,
  input logic irq_clr_i,
  input logic to_clr_i,
  input logic irq_flag_o,
  input logic to_flag_o,
  input logic rst_req_o,
  input logic warn_evt,
  input logic expire_evt
);

  AST_WARN_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_evt |=> irq_flag_o); // R2

  AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_evt |=> to_flag_o); // R3

  AST_STAGES_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(warn_evt && expire_evt)); // R3

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_o && !irq_clr_i) |=> irq_flag_o); // R5

  AST_IRQ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !warn_evt) |=> !irq_flag_o); // R5

  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R6

  AST_RST_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(expire_evt && rst_en_i)); // R6

  AST_TO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_flag_o && !to_clr_i) |=> to_flag_o); // R7

endmodule

bind wdog_two_stage wdog_two_stage_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_en_i   (rst_en_i),
  .irq_clr_i  (irq_clr_i),
  .to_clr_i   (to_clr_i),
  .irq_flag_o (irq_flag_o),
  .to_flag_o  (to_flag_o),
  .rst_req_o  (rst_req_o),
  .warn_evt   (warn_evt),
  .expire_evt (expire_evt)
);

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;

  localparam int SHIFT = 12;
  localparam int GRACE = 512;

  // {mode[1:0], irq_en, rst_en}
  localparam logic [3:0] STIM [4] = '{4'b00_1_1, 4'b01_0_1, 4'b10_1_0, 4'b11_0_0};

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       irq_en, rst_en, restart, irq_clr, to_clr;
  logic       irq_flag, to_flag, irq, rst_req;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  wdog_two_stage #(.SHIFT(SHIFT), .GRACE(GRACE)) i_wdog_two_stage (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mode_i     (mode),
    .irq_en_i   (irq_en),
    .rst_en_i   (rst_en),
    .restart_i  (restart),
    .irq_clr_i  (irq_clr),
    .to_clr_i   (to_clr),
    .irq_flag_o (irq_flag),
    .to_flag_o  (to_flag),
    .irq_o      (irq),
    .rst_req_o  (rst_req)
  );

  function automatic int lim(input logic [1:0] m);
    return 1 << (17 + 3 * int'(m) - SHIFT);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // restart, clearing both flags on the same edge
  task automatic restart_clr(input logic [1:0] m);
    @(negedge clk);
    mode = m; restart = 1'b1; irq_clr = 1'b1; to_clr = 1'b1;
    @(negedge clk);
    restart = 1'b0; irq_clr = 1'b0; to_clr = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq_flag && n < 40000);
  endtask

  task automatic wait_to(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!to_flag && n < 40000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; mode = 2'b00; irq_en = 1'b0; rst_en = 1'b0;
    restart = 1'b0; irq_clr = 1'b0; to_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 irq_flag", int'(irq_flag), 0);
    check("R10 to_flag", int'(to_flag), 0);
    check("R10 rst_req", int'(rst_req | irq), 0);
    // R8: captured mode is 00 after reset, so the first interval is lim(0)
    mode = 2'b11;
    rst_n = 1'b1;
    wait_irq(n);
    check("R8 reset mode interval", n, lim(2'b00));

    // table walk: R1 R2 R3 R6 R7 R5
    foreach (STIM[i]) begin
      irq_en = STIM[i][1];
      rst_en = STIM[i][0];
      restart_clr(STIM[i][3:2]);
      check("R5 restart clears flags", int'(irq_flag | to_flag), 0);
      wait_irq(n);
      check("R1 interval length", n, lim(STIM[i][3:2]));
      check("R2 irq gated by enable", int'(irq), int'(STIM[i][1]));
      wait_to(n);
      check("R3 grace length", n, GRACE);
      check("R6 reset request", int'(rst_req), int'(STIM[i][0]));
      @(negedge clk);
      check("R6 single pulse", int'(rst_req), 0);
      check("R7 flag survives request", int'(to_flag), 1);
      irq_clr = 1'b1; to_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0; to_clr = 1'b0;
      check("R5 clear inputs", int'(irq_flag | to_flag), 0);
    end

    // R8: mode change without restart has no effect
    irq_en = 1'b1; rst_en = 1'b1;
    restart_clr(2'b00);
    mode = 2'b11;
    wait_irq(n);
    check("R8 mode change ignored", n, lim(2'b00));

    // R4: restart inside the grace window stops the timeout
    restart_clr(2'b00);
    wait_irq(n);
    repeat (100) @(negedge clk);
    restart_clr(2'b00);
    wait_irq(n);
    check("R4 restart in grace interval", n, lim(2'b00));
    check("R4 no timeout after grace restart", int'(to_flag | rst_req), 0);

    // R4: restart on the interval end edge wins
    restart_clr(2'b00);
    repeat (lim(2'b00) - 1) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check("R4 restart beats terminal", int'(irq_flag), 0);
    wait_irq(n);
    check("R4 full interval after collision", n, lim(2'b00));

    // R5: clear on the set edge loses
    restart_clr(2'b00);
    repeat (lim(2'b00) - 1) @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check("R5 set beats clear", int'(irq_flag), 1);

    // R3: grace runs with irq disabled and flag cleared; then R9 free run
    irq_en = 1'b0; rst_en = 1'b0;
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    wait_to(n);
    check("R3 grace with flag cleared", n, GRACE - 1);
    check("R6 no request when disabled", int'(rst_req), 0);
    irq_clr = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      irq_clr = 1'b0;
      n++;
    end while (!irq_flag && n < 40000);
    check("R9 next interval after timeout", n, lim(2'b00));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule